// File: doc/BRIEF.md
# Interrupt Controller with Folded Sub-Sources

This block collects interrupt requests for a processor. It has up to 32 main sources and a smaller set of sub-sources. Each request can arrive on a pulse input or on a level input. A pulse sets a pending bit once, and that bit stays set until software clears it. A level input sets its pending bit again on every cycle for as long as it stays high. Three groups of three sub-sources are each folded into one fixed main pending bit, so software can share one main line among several peripheral causes. Each sub-source can be masked before folding.

Every clock cycle the controller checks the unmasked pending main sources. If any of them is in fast mode, it raises the fast interrupt output, and normal selection is skipped for that cycle. Otherwise it picks the lowest-numbered unmasked pending source. It records that source in a one-hot in-service register and stores its index in an offset register. The in-service register is only replaced by a request with a lower index. The normal interrupt output follows the in-service register. Software reaches eight word registers over a simple write/read bus. The register index comes from address bits [4:2], and read data is registered.

Top module: `irq_fold_ctrl`

## Requirements
- R1: The register index is taken from bus_addr[4:2]. The mapping is 0 main pending, 1 mode (1 = fast), 2 mask (1 = masked), 3 priority (storage only), 4 in-service, 5 offset, 6 sub-pending, 7 sub-mask. A read returns the stored value on rd_data_o one cycle after the address is presented, and unused upper sub-source bits read as zero.
- R2: After a synchronous reset, every register reads zero, with three exceptions: mask reads 0xFFFFFFFF, priority reads 0x7F and sub-mask reads 0x7FF. irq_o and fiq_o are low.
- R3: A write to index 0, 4 or 6 clears every bit written as 1 and leaves the other bits unchanged. A write to any other index replaces the whole register.
- R4: A one-cycle pulse on src_edge_i[n] sets main pending bit n, and the bit stays set until a clear write.
- R5: While src_lvl_i[n] or sub_lvl_i[n] is high, the matching pending bit is set again every cycle, so a clear write to it has no lasting effect.
- R6: A sub-source is active when its sub-pending bit is 1 and its sub-mask bit is 0. Any active sub-source among bits 0..2 sets main pending bit 28, bits 3..5 set bit 23, and bits 6..8 set bit 15. Bits 9 and 10 fold nowhere.
- R7: fiq_o is high exactly when some pending, unmasked main source has its mode bit set. In that evaluation the in-service and offset registers are not loaded.
- R8: With no fast request, the lowest-numbered pending unmasked source is loaded, one-hot into in-service and as an index into offset. This happens only if in-service is empty or holds a higher-numbered bit.
- R9: irq_o is high exactly when the in-service register is nonzero.
- R10: Any register write or input change shows on irq_o, fiq_o, sel_idx_o and the registers one clock edge later.
- R11: Reading any register, the offset register included, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_edge_i | input | 32 | Pulse requests for the main sources |
| src_lvl_i | input | 32 | Level requests for the main sources |
| sub_edge_i | input | 11 | Pulse requests for the sub-sources |
| sub_lvl_i | input | 11 | Level requests for the sub-sources |
| wr_en | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| wr_data | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| sel_idx_o | output | 5 | Offset register: index of the selected source |

## Verification
All state, including the chain from sub-source fold through the fast-mode check and the selection, is computed in a single cycle. A write or input change applied before one edge therefore appears on irq_o, fiq_o and sel_idx_o right after that edge. Read data shows the register contents from before the same edge. The bench drives inputs at the falling edge, advances its reference model exactly one edge, and compares every output at the following falling edge. Directed cases then use register reads to check pending, folding and clear effects at that same one-edge distance.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    RI_PND  = 3'd0,
    RI_MODE = 3'd1,
    RI_MASK = 3'd2,
    RI_PRIO = 3'd3,
    RI_INSV = 3'd4,
    RI_OFFS = 3'd5,
    RI_SPND = 3'd6,
    RI_SMSK = 3'd7
  } reg_idx_e;

  localparam int NUM_REGS = 8;
  localparam int DST_W    = 8;
endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [irqc_pkg::NUM_REGS*DATA_W-1:0] rd_words,
  output logic [irqc_pkg::NUM_REGS-1:0]   wr_sel,
  output logic [DATA_W-1:0]               rd_word
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] ridx;
  logic          unused_lo;

  assign ridx      = addr[ADDR_W-1:2];
  assign unused_lo = ^addr[1:0];

  for (genvar i = 0; i < irqc_pkg::NUM_REGS; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (ridx == IW'(i));
  end

  assign rd_word = rd_words[ridx*DATA_W +: DATA_W];
endmodule

// File: rtl/irqc_subfold.sv
module irqc_subfold #(
  parameter int NSRC  = 32,
  parameter int NSUB  = 11,
  parameter int GRP_N = 3,
  parameter int GRP_W = 3,
  parameter logic [GRP_N*irqc_pkg::DST_W-1:0] GRP_DST = {8'd15, 8'd23, 8'd28}
) (
  input  logic [NSUB-1:0] active,
  output logic [NSRC-1:0] fold
);
  localparam int IDX_W = $clog2(NSRC);

  always_comb begin
    fold = '0;
    for (int g = 0; g < GRP_N; g++) begin
      if (|active[g*GRP_W +: GRP_W])
        fold[GRP_DST[g*irqc_pkg::DST_W +: IDX_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N = 32
) (
  input  logic [N-1:0]         req,
  output logic                 any,
  output logic [N-1:0]         onehot,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IDX_W = $clog2(N);

  assign any    = |req;
  assign onehot = req & (~req + 1'b1);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_fold_ctrl.sv
module irq_fold_ctrl #(
  parameter int NSRC     = 32,
  parameter int NSUB     = 11,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int GRP_N    = 3,
  parameter int GRP_W    = 3,
  parameter logic [GRP_N*irqc_pkg::DST_W-1:0] GRP_DST = {8'd15, 8'd23, 8'd28},
  parameter logic [31:0] PRIO_RST = 32'h7F
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         src_edge_i,
  input  logic [NSRC-1:0]         src_lvl_i,
  input  logic [NSUB-1:0]         sub_edge_i,
  input  logic [NSUB-1:0]         sub_lvl_i,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    irq_o,
  output logic                    fiq_o,
  output logic [$clog2(NSRC)-1:0] sel_idx_o
);
  import irqc_pkg::*;

  localparam int IDX_W = $clog2(NSRC);

  // stored state
  logic [NSRC-1:0]   src_pnd_q, mode_q, mask_q, insv_q;
  logic [DATA_W-1:0] prio_q;
  logic [NSUB-1:0]   sub_pnd_q, sub_msk_q;

  // next-state terms
  logic [NUM_REGS-1:0] wr_sel;
  logic [NUM_REGS*DATA_W-1:0] rd_words;
  logic [DATA_W-1:0] rd_word;
  logic [NSRC-1:0]   wd_src, src_clr, insv_clr;
  logic [NSUB-1:0]   wd_sub, sub_clr;
  logic [NSRC-1:0]   src_pnd_n, mode_n, mask_n, insv_base, insv_n, ints, fold, pick_oh;
  logic [NSUB-1:0]   sub_pnd_n, sub_msk_n, sub_act;
  logic [DATA_W-1:0] prio_n;
  logic [IDX_W-1:0]  offs_base, offs_n, pick_idx;
  logic              pick_any, fiq_n, take;

  assign wd_src = wr_data[NSRC-1:0];
  assign wd_sub = wr_data[NSUB-1:0];

  irqc_regdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_en    (wr_en),
    .addr     (bus_addr),
    .rd_words (rd_words),
    .wr_sel   (wr_sel),
    .rd_word  (rd_word)
  );

  // sub-source stage
  assign sub_clr   = wr_sel[RI_SPND] ? wd_sub : '0;
  assign sub_pnd_n = (sub_pnd_q & ~sub_clr) | sub_edge_i | sub_lvl_i;
  assign sub_msk_n = wr_sel[RI_SMSK] ? wd_sub : sub_msk_q;
  assign sub_act   = sub_pnd_n & ~sub_msk_n;

  irqc_subfold #(
    .NSRC(NSRC), .NSUB(NSUB), .GRP_N(GRP_N), .GRP_W(GRP_W), .GRP_DST(GRP_DST)
  ) u_fold (
    .active (sub_act),
    .fold   (fold)
  );

  // main stage
  assign src_clr   = wr_sel[RI_PND] ? wd_src : '0;
  assign src_pnd_n = (src_pnd_q & ~src_clr) | src_edge_i | src_lvl_i | fold;
  assign mode_n    = wr_sel[RI_MODE] ? wd_src : mode_q;
  assign mask_n    = wr_sel[RI_MASK] ? wd_src : mask_q;
  assign prio_n    = wr_sel[RI_PRIO] ? wr_data : prio_q;
  assign ints      = src_pnd_n & ~mask_n;
  assign fiq_n     = |(ints & mode_n);

  irqc_pick #(.N(NSRC)) u_pick (
    .req    (ints),
    .any    (pick_any),
    .onehot (pick_oh),
    .idx    (pick_idx)
  );

  assign insv_clr  = wr_sel[RI_INSV] ? wd_src : '0;
  assign insv_base = insv_q & ~insv_clr;
  assign offs_base = wr_sel[RI_OFFS] ? wr_data[IDX_W-1:0] : sel_idx_o;
  assign take      = !fiq_n && pick_any && ((insv_base == '0) || (insv_base > pick_oh));
  assign insv_n    = take ? pick_oh : insv_base;
  assign offs_n    = take ? pick_idx : offs_base;

  assign rd_words = {DATA_W'(sub_msk_q), DATA_W'(sub_pnd_q), DATA_W'(sel_idx_o),
                     DATA_W'(insv_q), prio_q, DATA_W'(mask_q), DATA_W'(mode_q),
                     DATA_W'(src_pnd_q)};

  always_ff @(posedge clk) begin
    if (rst) begin
      src_pnd_q <= '0;
      mode_q    <= '0;
      mask_q    <= '1;
      prio_q    <= DATA_W'(PRIO_RST);
      insv_q    <= '0;
      sel_idx_o <= '0;
      sub_pnd_q <= '0;
      sub_msk_q <= '1;
      fiq_o     <= 1'b0;
      irq_o     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      src_pnd_q <= src_pnd_n;
      mode_q    <= mode_n;
      mask_q    <= mask_n;
      prio_q    <= prio_n;
      insv_q    <= insv_n;
      sel_idx_o <= offs_n;
      sub_pnd_q <= sub_pnd_n;
      sub_msk_q <= sub_msk_n;
      fiq_o     <= fiq_n;
      irq_o     <= |insv_n;
      rd_data_o <= rd_word;
    end
  end

  // checks on stored state
  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
    !wr_sel[RI_PND] |=> ((src_pnd_q & $past(src_pnd_q)) == $past(src_pnd_q))); // R4
  AST_LEVEL_RESET: assert property (@(posedge clk) disable iff (rst)
    (|src_lvl_i) |=> ((src_pnd_q & $past(src_lvl_i)) == $past(src_lvl_i))); // R5
  AST_FIQ_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (fiq_o && !$past(wr_sel[RI_INSV])) |-> (insv_q == $past(insv_q))); // R7
  AST_INSV_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(insv_q)); // R8
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    irq_o == (insv_q != '0)); // R9

  for (genvar g = 0; g < GRP_N; g++) begin : g_fold_chk
    AST_FOLD_SET: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && (|(sub_pnd_q[g*GRP_W +: GRP_W] & ~sub_msk_q[g*GRP_W +: GRP_W])))
      |=> src_pnd_q[GRP_DST[g*DST_W +: IDX_W]]); // R6
  end
endmodule

// File: tb/irq_fold_ctrl_test.sv
`timescale 1ns/1ps
module irq_fold_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_edge_i = '0, src_lvl_i = '0;
  logic [10:0] sub_edge_i = '0, sub_lvl_i = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data_o;
  logic        irq_o, fiq_o;
  logic [4:0]  sel_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_pnd, m_mode, m_mask, m_prio, m_insv;
  logic [4:0]  m_offs;
  logic [10:0] m_spnd, m_smsk;
  logic        m_fiq, m_irq;

  always #4 clk = ~clk;

  irq_fold_ctrl uut (
    .clk(clk), .rst(rst), .src_edge_i(src_edge_i), .src_lvl_i(src_lvl_i),
    .sub_edge_i(sub_edge_i), .sub_lvl_i(sub_lvl_i), .wr_en(wr_en),
    .bus_addr(bus_addr), .wr_data(wr_data), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .fiq_o(fiq_o), .sel_idx_o(sel_idx_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] lowest(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  function automatic logic [4:0] low_idx(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) low_idx = 5'(i);
    if (v == 0) low_idx = 0;
  endfunction

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_pnd;
      3'd1: return m_mode;
      3'd2: return m_mask;
      3'd3: return m_prio;
      3'd4: return m_insv;
      3'd5: return {27'd0, m_offs};
      3'd6: return {21'd0, m_spnd};
      default: return {21'd0, m_smsk};
    endcase
  endfunction

  task automatic mreset();
    m_pnd = 0; m_mode = 0; m_mask = '1; m_prio = 32'h7F; m_insv = 0;
    m_offs = 0; m_spnd = 0; m_smsk = 11'h7FF; m_fiq = 0; m_irq = 0;
  endtask

  // one clock edge: model next state, then compare at the next falling edge
  task automatic step();
    logic [2:0]  a;
    logic [31:0] exp_rd, n_pnd, n_mode, n_mask, n_prio, n_insv, ints, fold, oh;
    logic [10:0] n_spnd, n_smsk, act;
    logic [4:0]  n_offs;
    logic        n_fiq;
    a = bus_addr[4:2];
    exp_rd = mread(a);
    n_spnd = (m_spnd & ~((wr_en && a == 6) ? wr_data[10:0] : 11'd0)) | sub_edge_i | sub_lvl_i;
    n_smsk = (wr_en && a == 7) ? wr_data[10:0] : m_smsk;
    act = n_spnd & ~n_smsk;
    fold = 0;
    if (|act[2:0]) fold[28] = 1'b1;
    if (|act[5:3]) fold[23] = 1'b1;
    if (|act[8:6]) fold[15] = 1'b1;
    n_pnd  = (m_pnd & ~((wr_en && a == 0) ? wr_data : 32'd0)) | src_edge_i | src_lvl_i | fold;
    n_mode = (wr_en && a == 1) ? wr_data : m_mode;
    n_mask = (wr_en && a == 2) ? wr_data : m_mask;
    n_prio = (wr_en && a == 3) ? wr_data : m_prio;
    n_insv = m_insv & ~((wr_en && a == 4) ? wr_data : 32'd0);
    n_offs = (wr_en && a == 5) ? wr_data[4:0] : m_offs;
    ints = n_pnd & ~n_mask;
    n_fiq = |(ints & n_mode);
    oh = lowest(ints);
    if (!n_fiq && ints != 0 && (n_insv == 0 || n_insv > oh)) begin
      n_insv = oh;
      n_offs = low_idx(ints);
    end
    @(negedge clk);
    m_pnd = n_pnd; m_mode = n_mode; m_mask = n_mask; m_prio = n_prio;
    m_insv = n_insv; m_offs = n_offs; m_spnd = n_spnd; m_smsk = n_smsk;
    m_fiq = n_fiq; m_irq = (n_insv != 0);
    chk("R1 rd_data", rd_data_o, exp_rd);
    chk("R7 fiq_o", {31'd0, fiq_o}, {31'd0, m_fiq});
    chk("R9 irq_o", {31'd0, irq_o}, {31'd0, m_irq});
    chk("R8 sel_idx_o", {27'd0, sel_idx_o}, {27'd0, m_offs});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; bus_addr = {a, 2'b00}; wr_data = d;
    step();
    wr_en = 0; wr_data = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
    bus_addr = {a, 2'b00};
    step();
    chk(tag, rd_data_o, exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    mreset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R2: reset values
    rd(3'd0, "R2 pnd", 32'h0);
    rd(3'd2, "R2 mask", 32'hFFFF_FFFF);
    rd(3'd3, "R2 prio", 32'h7F);
    rd(3'd7, "R2 submask", 32'h7FF);
    rd(3'd4, "R2 insv", 32'h0);
    chk("R2 irq", {31'd0, irq_o}, 32'd0);

    // R4: pulse latches, R10: irq the next edge
    wr(3'd2, ~32'h0000_0060);           // unmask 5 and 6
    src_edge_i = 32'h20; step(); src_edge_i = 0;
    chk("R10 irq after pulse", {31'd0, irq_o}, 32'd1);
    chk("R4 idx", {27'd0, sel_idx_o}, 32'd5);
    repeat (3) step();
    rd(3'd0, "R4 latched", 32'h20);
    // R8: higher index does not replace
    src_edge_i = 32'h40; step(); src_edge_i = 0;
    chk("R8 keep lower", {27'd0, sel_idx_o}, 32'd5);
    // R3: clear-on-one leaves others; R11: offset read harmless
    wr(3'd0, 32'h20);
    rd(3'd0, "R3 w1c pnd", 32'h40);
    rd(3'd5, "R11 offs", 32'd5);
    rd(3'd5, "R11 offs again", 32'd5);
    wr(3'd4, 32'h20);
    chk("R8 reload 6", {27'd0, sel_idx_o}, 32'd6);
    wr(3'd3, 32'h0000_1234);
    rd(3'd3, "R3 replace prio", 32'h1234);

    // R5: level resets pending despite clear
    wr(3'd2, 32'hFFFF_FFFF);
    src_lvl_i = 32'h8; step();
    wr(3'd0, 32'h8);
    rd(3'd0, "R5 level holds", 32'h48);
    src_lvl_i = 0; step();
    wr(3'd0, 32'h48);
    rd(3'd0, "R5 cleared after drop", 32'h0);

    // R6: fold groups
    wr(3'd7, 32'h0);
    sub_edge_i = 11'h010; step(); sub_edge_i = 0;
    rd(3'd0, "R6 bit23", 32'h0080_0000);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, "R6 refold", 32'h0080_0000);
    wr(3'd6, 32'h7FF);
    wr(3'd0, 32'hFFFF_FFFF);
    sub_edge_i = 11'h600; step(); sub_edge_i = 0;
    rd(3'd0, "R6 no fold 9-10", 32'h0);
    rd(3'd6, "R6 sub pending", 32'h600);
    sub_edge_i = 11'h005; wr(3'd7, 32'h7FE); sub_edge_i = 0;
    rd(3'd0, "R6 bit28", 32'h1000_0000);
    wr(3'd6, 32'h7FF); wr(3'd0, 32'hFFFF_FFFF);

    // R7: fast mode steers and freezes selection
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd1, 32'h4);
    wr(3'd2, 32'hFFFF_FFF0);
    src_edge_i = 32'h6; step(); src_edge_i = 0;
    chk("R7 fiq on", {31'd0, fiq_o}, 32'd1);
    chk("R7 no irq load", {31'd0, irq_o}, 32'd0);
    wr(3'd0, 32'h4);
    chk("R7 fiq off", {31'd0, fiq_o}, 32'd0);
    chk("R8 after fiq", {27'd0, sel_idx_o}, 32'd1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      src_edge_i = (($urandom % 8) == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
      src_lvl_i  = (($urandom % 16) == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
      sub_edge_i = (($urandom % 8) == 0) ? 11'(1 << ($urandom % 11)) : 11'd0;
      sub_lvl_i  = (($urandom % 20) == 0) ? 11'(1 << ($urandom % 11)) : 11'd0;
      bus_addr   = 5'($urandom % 32);
      wr_en      = (($urandom % 4) == 0);
      wr_data    = $urandom;
      if (bus_addr[4:2] == 3'd1) wr_data = wr_data & 32'h0000_0101;
      step();
    end
    wr_en = 0;
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog got=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule